// File: doc/BRIEF.md
# Interrupt Wake-Up Notifier

This block sits between the place where interrupts are queued and a group of processors. When a new interrupt of one class becomes pending (service, I/O or machine-check), a one-cycle notify pulse arrives. The block then raises a sticky interrupt-request bit on every processor. It also decides, for each processor, whether that processor gets a one-cycle wake-up kick.

Each processor reports its run state, a halted flag and three enable bits, one for each interrupt class. A processor that is not in a running state gets no kick. A running processor that is not halted always gets one. A halted running processor gets a kick only when its enable bit for the notified class is set. An interrupt-request bit stays set until that processor acknowledges it. The number of processors is a parameter.

Top module: `irq_wake_notifier`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every interrupt-request bit and every kick output is 0.
- R2: A notify pulse with any bit set makes every interrupt-request bit 1 in the next cycle. This holds whatever each processor's run state, halted flag and enable bits are.
- R3: An interrupt-request bit stays 1 until its acknowledge input is high. An acknowledge without a notify clears the bit in the next cycle. If notify and acknowledge arrive in the same cycle, the bit is 1 in the next cycle.
- R4: Run state codes are 0 stopped, 1 check-stop, 2 operating and 3 load. A processor whose code is 0 or 1 is never kicked.
- R5: A processor in code 2 or 3 whose halted flag is 0 is kicked, whatever its enable bits are.
- R6: For a service notification, a halted processor in code 2 or 3 is kicked only when its external-interrupt enable bit is 1.
- R7: For an I/O notification, a halted processor in code 2 or 3 is kicked only when its I/O enable bit is 1.
- R8: For a machine-check notification, a halted processor in code 2 or 3 is kicked only when its machine-check enable bit is 1.
- R9: The notify input is encoded as bit 0 service, bit 1 I/O, bit 2 machine-check. If more than one bit is set, the class for the enable check is chosen in the order service, then I/O, then machine-check.
- R10: A kick appears exactly one cycle after the notify pulse. It lasts one cycle for a single-cycle pulse. No kick appears in a cycle that does not follow a notify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| notify_i | input | 3 | One-cycle notify pulse; bit 0 service, bit 1 I/O, bit 2 machine-check |
| run_state_i | input | 2*NUM_CPU | Run state code per processor; processor k uses bits [2k+1:2k] |
| halted_i | input | NUM_CPU | Halted flag per processor |
| en_ext_i | input | NUM_CPU | External-interrupt enable per processor |
| en_io_i | input | NUM_CPU | I/O interrupt enable per processor |
| en_mchk_i | input | NUM_CPU | Machine-check enable per processor |
| ack_i | input | NUM_CPU | Clears the interrupt-request bit of that processor |
| irq_req_o | output | NUM_CPU | Sticky interrupt-request bit per processor |
| kick_o | output | NUM_CPU | One-cycle wake-up kick per processor |

## Verification
Both results go through one register stage. The request bits and the kick are therefore due in the cycle after the notify edge, and an acknowledge clears its request bit in the cycle after it is sampled. The bench changes inputs on the falling edge and samples on the next falling edge, which is half a cycle after the register has loaded. A further falling-edge sample confirms that the kick has dropped again. The request checks are repeated over several idle cycles to show that the bits hold until an acknowledge.

// File: rtl/wake_pkg.sv
// Package: shared class indices and run-state codes for the wake-up notifier.
// Assumes the notify vector has one bit per interrupt class, in index order.
package wake_pkg;

    localparam int CLS_W    = 3;
    localparam int CLS_SVC  = 0;
    localparam int CLS_IO   = 1;
    localparam int CLS_MCHK = 2;

    typedef enum logic [1:0] {
        RS_STOPPED   = 2'd0,
        RS_CHECKSTOP = 2'd1,
        RS_OPERATING = 2'd2,
        RS_LOAD      = 2'd3
    } run_state_e;

endpackage

// File: rtl/wake_class_decode.sv
// Module: wake_class_decode
// Turns the raw notify vector into a one-hot class selection, with the
// lowest index first (service, then I/O, then machine-check).
// Assumes: notify is normally one-hot; any extra bits are resolved by priority.
module wake_class_decode
    import wake_pkg::*;
#(
    parameter int NUM_CLS = CLS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CLS-1:0] notify_i,
    output logic [NUM_CLS-1:0] cls_oh_o,
    output logic               any_o
);

    // Priority pick: the lowest set notify bit wins.
    always_comb begin
        cls_oh_o = '0;
        for (int i = NUM_CLS - 1; i >= 0; i--) begin
            if (notify_i[i]) begin
                cls_oh_o = '0;
                cls_oh_o[i] = 1'b1;
            end
        end
    end

    // Any class notified.
    assign any_o = |notify_i;

    // R9: service bit present means the service class is selected alone.
    a_r9_svc_first: assert property (@(posedge clk) disable iff (!rst_n)
        notify_i[CLS_SVC] |-> (cls_oh_o == NUM_CLS'(1 << CLS_SVC)));

    // R9: I/O without service selects I/O.
    a_r9_io_next: assert property (@(posedge clk) disable iff (!rst_n)
        (!notify_i[CLS_SVC] && notify_i[CLS_IO]) |-> cls_oh_o[CLS_IO]);

endmodule

// File: rtl/wake_cpu_slice.sv
// Module: wake_cpu_slice
// Per-processor logic: holds the sticky interrupt-request bit and registers
// the kick decision from run state, halted flag and the class-matched enable.
// Assumes: cls_oh_i is one-hot whenever notify_any_i is high.
module wake_cpu_slice
    import wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             notify_any_i,
    input  logic [CLS_W-1:0] cls_oh_i,
    input  logic [1:0]       run_state_i,
    input  logic             halted_i,
    input  logic             en_ext_i,
    input  logic             en_io_i,
    input  logic             en_mchk_i,
    input  logic             ack_i,
    output logic             irq_req_o,
    output logic             kick_o
);

    logic             run_ok;
    logic [CLS_W-1:0] en_vec;
    logic             en_sel;
    logic             kick_d;

    // Running means operating or load.
    assign run_ok = (run_state_i == RS_OPERATING) || (run_state_i == RS_LOAD);

    // Enable bits placed in class-index order.
    always_comb begin
        en_vec           = '0;
        en_vec[CLS_SVC]  = en_ext_i;
        en_vec[CLS_IO]   = en_io_i;
        en_vec[CLS_MCHK] = en_mchk_i;
    end

    // Enable that matches the selected class.
    assign en_sel = |(cls_oh_i & en_vec);

    // Kick decision: running, and either awake or enabled for this class.
    assign kick_d = notify_any_i && run_ok && (!halted_i || en_sel);

    // Sticky request: a notify sets it, an acknowledge clears it, and notify wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req_o <= 1'b0;
        end else if (notify_any_i) begin
            irq_req_o <= 1'b1;
        end else if (ack_i) begin
            irq_req_o <= 1'b0;
        end
    end

    // Registered one-cycle kick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kick_o <= 1'b0;
        end else begin
            kick_o <= kick_d;
        end
    end

    // R3: the request holds without an acknowledge.
    a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !ack_i) |=> irq_req_o);

    // R3: an acknowledge alone clears the request.
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !notify_any_i) |=> !irq_req_o);

    // R4: stopped or check-stopped processors are never kicked.
    a_r4_no_kick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (notify_any_i && !run_state_i[1]) |=> !kick_o);

    // R5: running and awake is always kicked.
    a_r5_awake_kick: assert property (@(posedge clk) disable iff (!rst_n)
        (notify_any_i && run_state_i[1] && !halted_i) |=> kick_o);

    // R6: halted without external enable is not kicked on service.
    a_r6_svc_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (notify_any_i && cls_oh_i[CLS_SVC] && halted_i && !en_ext_i) |=> !kick_o);

    // R7: halted without I/O enable is not kicked on I/O.
    a_r7_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (notify_any_i && cls_oh_i[CLS_IO] && halted_i && !en_io_i) |=> !kick_o);

    // R8: halted without machine-check enable is not kicked on machine-check.
    a_r8_mchk_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (notify_any_i && cls_oh_i[CLS_MCHK] && halted_i && !en_mchk_i) |=> !kick_o);

    // R10: no kick follows a cycle without a notify.
    a_r10_kick_needs_notify: assert property (@(posedge clk) disable iff (!rst_n)
        !notify_any_i |=> !kick_o);

endmodule

// File: rtl/irq_wake_notifier.sv
// Module: irq_wake_notifier (top)
// Broadcasts a sticky interrupt request to every processor on each notify,
// and gives a filtered one-cycle wake-up kick to each processor.
// Assumes: notify_i is a one-cycle pulse; per-processor inputs are stable
// in the cycle the pulse is sampled.
module irq_wake_notifier
    import wake_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CLS_W-1:0]     notify_i,
    input  logic [2*NUM_CPU-1:0] run_state_i,
    input  logic [NUM_CPU-1:0]   halted_i,
    input  logic [NUM_CPU-1:0]   en_ext_i,
    input  logic [NUM_CPU-1:0]   en_io_i,
    input  logic [NUM_CPU-1:0]   en_mchk_i,
    input  logic [NUM_CPU-1:0]   ack_i,
    output logic [NUM_CPU-1:0]   irq_req_o,
    output logic [NUM_CPU-1:0]   kick_o
);

    localparam int RS_W = 2;

    logic [CLS_W-1:0] cls_oh;
    logic             notify_any;

    // Shared class decode.
    wake_class_decode #(
        .NUM_CLS (CLS_W)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .notify_i (notify_i),
        .cls_oh_o (cls_oh),
        .any_o    (notify_any)
    );

    // One slice per processor.
    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
        wake_cpu_slice u_slice (
            .clk          (clk),
            .rst_n        (rst_n),
            .notify_any_i (notify_any),
            .cls_oh_i     (cls_oh),
            .run_state_i  (run_state_i[k*RS_W +: RS_W]),
            .halted_i     (halted_i[k]),
            .en_ext_i     (en_ext_i[k]),
            .en_io_i      (en_io_i[k]),
            .en_mchk_i    (en_mchk_i[k]),
            .ack_i        (ack_i[k]),
            .irq_req_o    (irq_req_o[k]),
            .kick_o       (kick_o[k])
        );
    end

    // R2: any notify raises every request bit in the next cycle.
    a_r2_all_req: assert property (@(posedge clk) disable iff (!rst_n)
        (|notify_i) |=> (&irq_req_o));

    // R1: outputs are clear in the cycle after reset.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (irq_req_o == '0 && kick_o == '0));

endmodule

// File: tb/test_irq_wake_notifier.sv
`timescale 1ns/1ps
module test_irq_wake_notifier;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   notify = '0;
    logic [7:0]   rs = '0;
    logic [N-1:0] halt = '0, ext = '0, io = '0, mc = '0, ack = '0;
    logic [N-1:0] req, kick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_wake_notifier #(.NUM_CPU(N)) i_irq_wake_notifier (
        .clk(clk), .rst_n(rst_n), .notify_i(notify), .run_state_i(rs),
        .halted_i(halt), .en_ext_i(ext), .en_io_i(io), .en_mchk_i(mc),
        .ack_i(ack), .irq_req_o(req), .kick_o(kick)
    );

    // Vector: {notify[2:0], run_state[7:0], halted, ext_en, io_en, mchk_en, expected kick}
    // Run state codes: 0 stopped, 1 check-stop, 2 operating, 3 load.
    localparam int NV = 9;
    localparam logic [30:0] VEC [NV] = '{
        {3'b001, 8'hAA, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF},  // R5 all awake, service
        {3'b010, 8'h1E, 4'h0, 4'h0, 4'h0, 4'h0, 4'h3},  // R4 mixed run states
        {3'b001, 8'hAA, 4'hF, 4'h5, 4'hF, 4'hF, 4'h5},  // R6 halted, service
        {3'b010, 8'hAA, 4'hF, 4'hF, 4'hA, 4'h0, 4'hA},  // R7 halted, I/O
        {3'b100, 8'hFF, 4'hF, 4'hF, 4'hF, 4'h6, 4'h6},  // R8 halted, machine-check
        {3'b100, 8'hAA, 4'h3, 4'hF, 4'hF, 4'h0, 4'hC},  // R5 R8 mixed halted
        {3'b011, 8'hAA, 4'hF, 4'h1, 4'hE, 4'h0, 4'h1},  // R9 service over I/O
        {3'b110, 8'hAA, 4'hF, 4'h0, 4'h4, 4'hB, 4'h4},  // R9 I/O over machine-check
        {3'b001, 8'h55, 4'hF, 4'hF, 4'hF, 4'hF, 4'h0}   // R4 check-stop all
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 req in reset", req, '0);
        check("R1 kick in reset", kick, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req after reset", req, '0);
        check("R1 kick after reset", kick, '0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            {notify, rs, halt, ext, io, mc} = VEC[v][30:4];
            @(negedge clk);
            notify = '0;
            check($sformatf("R2 req vec %0d", v), req, '1);
            check($sformatf("R4-8 kick vec %0d", v), kick, VEC[v][3:0]);
            @(negedge clk);
            check($sformatf("R10 kick width vec %0d", v), kick, '0);
            ack = '1;
            @(negedge clk);
            ack = '0;
            check($sformatf("R3 ack clear vec %0d", v), req, '0);
        end

        // R3 sticky hold and partial acknowledge
        rs = 8'h00; halt = '1; ext = '0; io = '0; mc = '0;
        notify = 3'b100;
        @(negedge clk);
        notify = '0;
        check("R2 req with all stopped", req, '1);
        check("R4 no kick all stopped", kick, '0);
        repeat (4) @(negedge clk);
        check("R3 req held", req, '1);
        ack = 4'b0100;
        @(negedge clk);
        ack = '0;
        check("R3 partial ack", req, 4'b1011);
        ack = '1; notify = 3'b010;
        @(negedge clk);
        ack = '0; notify = '0;
        check("R3 notify beats ack", req, '1);

        // R10 no kick without notify
        rs = 8'hAA; halt = '0;
        repeat (3) begin
            @(negedge clk);
            check("R10 idle no kick", kick, '0);
        end

        // R1 reset clears held state
        notify = 3'b001;
        @(negedge clk);
        notify = '0;
        check("R5 kick before reset", kick, '1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 req cleared by reset", req, '0);
        check("R1 kick cleared by reset", kick, '0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule